// File: doc/BRIEF.md
# Video Controller Byte-Port Register Interface

This block is the processor-facing side of a video controller. A CPU with an 8-bit data bus reaches it through a 2-bit port offset. One offset picks which internal 16-bit register the next access targets. Two more offsets carry the low and the high byte of that register's value. Every 16-bit value travels as a pair of bytes, low byte first. The low byte waits in a holding latch, and the write to the high-byte port commits the whole word to the selected register.

Three registers are implemented. Register 0 holds the write pointer and register 1 holds the read pointer. Register 2 is the data window into a word-addressed video memory, where each address holds one 16-bit word and neighbouring addresses share no bytes. Committing a word to the data window stores it at the write pointer, and the write pointer then advances by one. Committing a read pointer fetches the word at that address into a read buffer. The CPU reads that buffer back one byte at a time through the low-byte and high-byte ports. Reading the high byte advances the read pointer and fetches the next word.

The memory holds 2^`RAM_AW` words. The full chip builds it with `RAM_AW` = 15, which gives 32K words or 64 KB. The pointers are always 16 bits wide, and the pointer bits above the populated range play no part in addressing.

Top module: `vid_regport`

## Requirements
- R1: After reset the register select, the write pointer, the read pointer and the read buffer are all zero, so a read of offset 2 returns 0x00.
- R2: A write to offset 0 loads the full 8-bit register select. A write to offset 1 changes nothing.
- R3: A write to offset 2 only updates the low-byte latch. A write to offset 3 commits {offset-3 byte, latched low byte} to the register that is selected at the time of that write, even if the select changed after the low byte was written.
- R4: A commit to register 0 sets the write pointer. A commit to register 2 stores the word in memory at the current write pointer.
- R5: After each commit to register 2 the write pointer increases by one, wrapping modulo 2^16.
- R6: Only the low `RAM_AW` pointer bits address the memory, so pointers that differ only above that range reach the same word.
- R7: A commit to register 1 sets the read pointer and loads the word at that address into the read buffer. While register 2 is selected, offset 2 reads return buffer bits 7:0 and offset 3 reads return buffer bits 15:8. The read data is combinational from the buffer and the port offset.
- R8: While register 2 is selected, a read of offset 3 advances the read pointer by one and reloads the buffer from the new address. A read of offset 2 advances nothing.
- R9: A commit to any register number other than 0, 1 or 2 is discarded. It leaves both pointers, the buffer and the memory unchanged.
- R10: While a register other than 2 is selected, every read returns 0x00 and moves neither the read pointer nor the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_sel | input | 2 | Port offset: 0 select, 1 unused, 2 low byte, 3 high byte |
| wr_en | input | 1 | Byte write strobe for this cycle |
| rd_en | input | 1 | Byte read strobe for this cycle |
| wr_data | input | 8 | Byte written by the CPU |
| rd_data | output | 8 | Byte returned to the CPU |

## Verification
The assertions assume that a write strobe and a read strobe are never high in the same cycle, since one CPU bus cycle is either a read or a write. They also assume that each strobe lasts a single clock for a single byte access. The bench drives every access through one bus task that raises exactly one strobe for one cycle and then drops it, and this holds for both the random and the directed phases. The memory is filled completely before any read that advances the read pointer, so every word that is fetched has a known value. Random pointers span the whole 16-bit range, so the aliasing above the populated range is exercised.

// File: rtl/vid_regport_pkg.sv
package vid_regport_pkg;

    // Port offsets seen by the CPU
    typedef enum logic [1:0] {
        PORT_SEL = 2'd0,
        PORT_RSV = 2'd1,
        PORT_LO  = 2'd2,
        PORT_HI  = 2'd3
    } port_e;

    localparam int SEL_W  = 8;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    localparam logic [SEL_W-1:0] REG_WPTR = 8'd0;
    localparam logic [SEL_W-1:0] REG_RPTR = 8'd1;
    localparam logic [SEL_W-1:0] REG_DATA = 8'd2;

    // Byte-pair assembler state
    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [BYTE_W-1:0] lo;
    } pair_st_t;

    // Pointer and buffer state of the top level
    typedef struct packed {
        logic [WORD_W-1:0] wptr;
        logic [WORD_W-1:0] rptr;
        logic [WORD_W-1:0] rbuf;
    } ptr_st_t;

endpackage

// File: rtl/vid_word_ram.sv
module vid_word_ram #(
    parameter int AW = 11,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    // Storage has no reset; contents are defined only after being written
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Asynchronous read so that a fetch lands in the buffer on the same edge
    assign rdata = mem_q[raddr];

endmodule

// File: rtl/vid_pair_asm.sv
module vid_pair_asm
    import vid_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        port_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [SEL_W-1:0]  reg_sel,
    output logic              commit,
    output logic [WORD_W-1:0] commit_word
);
    pair_st_t st_d, st_q;
    port_e    port;

    assign port = port_e'(port_sel);

    always_comb begin
        st_d        = st_q;
        commit      = 1'b0;
        commit_word = {wr_data, st_q.lo};
        if (wr_en) begin
            case (port)
                PORT_SEL: st_d.sel = wr_data;
                PORT_LO:  st_d.lo  = wr_data;
                PORT_HI:  commit   = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_sel = st_q.sel;

    // R2: the select takes the written byte
    a_r2_sel_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port_sel == 2'd0) |=> (st_q.sel == $past(wr_data)));

    // R2: the unused offset touches nothing
    a_r2_rsv_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port_sel == 2'd1) |=> ($stable(st_q.sel) && $stable(st_q.lo)));

    // R3: the low byte is latched
    a_r3_low_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port_sel == 2'd2) |=> (st_q.lo == $past(wr_data)));

    // R3: a high-byte write keeps the latch and the select
    a_r3_hi_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port_sel == 2'd3) |=> ($stable(st_q.lo) && $stable(st_q.sel)));

endmodule

// File: rtl/vid_regport.sv
module vid_regport
    import vid_regport_pkg::*;
#(
    parameter int RAM_AW = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] port_sel,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data
);
    localparam int DEPTH = 1 << RAM_AW;

    logic [SEL_W-1:0]  reg_sel;
    logic              commit;
    logic [WORD_W-1:0] commit_word;

    ptr_st_t st_d, st_q;

    logic              ram_we;
    logic [RAM_AW-1:0] ram_waddr;
    logic [RAM_AW-1:0] ram_raddr;
    logic [WORD_W-1:0] ram_rdata;

    logic              hi_read;
    logic              fetch;
    logic [WORD_W-1:0] rptr_next;

    vid_pair_asm u_pair (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .port_sel    (port_sel),
        .wr_data     (wr_data),
        .reg_sel     (reg_sel),
        .commit      (commit),
        .commit_word (commit_word)
    );

    // Read-side fetch control, kept apart from the state update
    always_comb begin
        hi_read   = rd_en && (port_sel == 2'd3) && (reg_sel == REG_DATA);
        fetch     = 1'b0;
        rptr_next = st_q.rptr;
        if (commit && reg_sel == REG_RPTR) begin
            rptr_next = commit_word;
            fetch     = 1'b1;
        end else if (hi_read) begin
            rptr_next = st_q.rptr + 16'd1;
            fetch     = 1'b1;
        end
        ram_raddr = rptr_next[RAM_AW-1:0];
    end

    vid_word_ram #(
        .AW (RAM_AW),
        .DW (WORD_W)
    ) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (commit_word),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    always_comb begin
        st_d      = st_q;
        ram_we    = 1'b0;
        ram_waddr = st_q.wptr[RAM_AW-1:0];
        if (commit) begin
            case (reg_sel)
                REG_WPTR: st_d.wptr = commit_word;
                REG_DATA: begin
                    ram_we    = 1'b1;
                    st_d.wptr = st_q.wptr + 16'd1;
                end
                default: ;
            endcase
        end
        st_d.rptr = rptr_next;
        if (fetch) begin
            st_d.rbuf = ram_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        if (reg_sel == REG_DATA) begin
            if (port_sel == 2'd2) begin
                rd_data = st_q.rbuf[7:0];
            end else if (port_sel == 2'd3) begin
                rd_data = st_q.rbuf[15:8];
            end
        end
    end

    // R3: one bus cycle is a read or a write, never both
    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));

    // R4: a commit to register 0 loads the write pointer
    a_r4_wptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && reg_sel == REG_WPTR) |=> (st_q.wptr == $past(commit_word)));

    // R5: the write pointer steps after each data commit
    a_r5_wptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && reg_sel == REG_DATA) |=> (st_q.wptr == $past(st_q.wptr) + 16'd1));

    // R7: a commit to register 1 loads the read pointer
    a_r7_rptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && reg_sel == REG_RPTR) |=> (st_q.rptr == $past(commit_word)));

    // R8: a high-byte read advances the read pointer
    a_r8_rptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && port_sel == 2'd3 && reg_sel == REG_DATA)
        |=> (st_q.rptr == $past(st_q.rptr) + 16'd1));

    // R8: a low-byte read leaves the read side alone
    a_r8_low_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && port_sel == 2'd2) |=> ($stable(st_q.rptr) && $stable(st_q.rbuf)));

    // R9: commits to unimplemented registers are dropped
    a_r9_unimpl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && reg_sel > REG_DATA)
        |=> ($stable(st_q.wptr) && $stable(st_q.rptr) && $stable(st_q.rbuf)));

    // R10: reads with another register selected return zero and move nothing
    a_r10_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_sel != REG_DATA) |-> (rd_data == 8'h00));

    a_r10_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_sel != REG_DATA) |=> ($stable(st_q.rptr) && $stable(st_q.rbuf)));

endmodule

// File: tb/vid_regport_tb_top.sv
`timescale 1ns/1ps
module vid_regport_tb_top;
    localparam int RAM_AW = 11;
    localparam int DEPTH  = 1 << RAM_AW;
    localparam logic [15:0] AMASK = 16'(DEPTH - 1);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] port_sel = 2'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // reference model state
    logic [15:0] ref_mem [DEPTH];
    logic [7:0]  m_sel = 8'd0;
    logic [7:0]  m_lo  = 8'd0;
    logic [15:0] m_wptr = 16'd0;
    logic [15:0] m_rptr = 16'd0;
    logic [15:0] m_rbuf = 16'd0;

    always #2.5 clk = ~clk;

    vid_regport #(.RAM_AW(RAM_AW)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_sel (port_sel),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data)
    );

    function automatic logic [15:0] fill_word(input int i);
        return 16'(i * 40503) ^ 16'h1234;
    endfunction

    function automatic logic [7:0] expect_rd(input logic [1:0] p);
        if (m_sel != 8'd2) return 8'h00;
        if (p == 2'd2) return m_rbuf[7:0];
        if (p == 2'd3) return m_rbuf[15:8];
        return 8'h00;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_wr(input logic [1:0] p, input logic [7:0] d);
        logic [15:0] w;
        case (p)
            2'd0: m_sel = d;
            2'd2: m_lo = d;
            2'd3: begin
                w = {d, m_lo};
                if (m_sel == 8'd0) m_wptr = w;
                else if (m_sel == 8'd1) begin
                    m_rptr = w;
                    m_rbuf = ref_mem[w & AMASK];
                end else if (m_sel == 8'd2) begin
                    ref_mem[m_wptr & AMASK] = w;
                    m_wptr = m_wptr + 16'd1;
                end
            end
            default: ;
        endcase
    endtask

    task automatic bus_wr(input logic [1:0] p, input logic [7:0] d);
        @(negedge clk);
        port_sel = p;
        wr_data  = d;
        wr_en    = 1'b1;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        model_wr(p, d);
    endtask

    task automatic bus_rd(input logic [1:0] p, input string tag);
        logic [7:0] exp;
        @(negedge clk);
        port_sel = p;
        rd_en    = 1'b1;
        exp      = expect_rd(p);
        #1;
        check(rd_data === exp, tag, {8'h00, rd_data}, {8'h00, exp});
        @(posedge clk);
        #1;
        rd_en = 1'b0;
        if (m_sel == 8'd2 && p == 2'd3) begin
            m_rptr = m_rptr + 16'd1;
            m_rbuf = ref_mem[m_rptr & AMASK];
        end
    endtask

    task automatic set_reg(input logic [7:0] r, input logic [15:0] w);
        bus_wr(2'd0, r);
        bus_wr(2'd2, w[7:0]);
        bus_wr(2'd3, w[15:8]);
    endtask

    task automatic read_word(input string tag);
        bus_rd(2'd2, tag);
        bus_rd(2'd3, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'h0BADF00D);
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 16'h0000;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state, select 0 then buffer through the data window
        bus_rd(2'd2, "R1");
        bus_wr(2'd0, 8'd2);
        bus_rd(2'd2, "R1");

        // fill memory so every fetch has a known value
        set_reg(8'd0, 16'h0000);
        bus_wr(2'd0, 8'd2);
        for (int i = 0; i < DEPTH; i++) begin
            bus_wr(2'd2, fill_word(i) & 16'h00FF);
            bus_wr(2'd3, 8'(fill_word(i) >> 8));
        end

        // R4 / R5: consecutive data writes land in consecutive words
        set_reg(8'd0, 16'h0040);
        set_reg(8'd2, 16'hA1B2);
        set_reg(8'd2, 16'hC3D4);
        set_reg(8'd2, 16'hE5F6);
        set_reg(8'd1, 16'h0040);
        bus_wr(2'd0, 8'd2);
        read_word("R4");
        read_word("R5");
        read_word("R5");

        // R6: pointer above the populated range aliases
        set_reg(8'd0, 16'(DEPTH) | 16'h0005);
        set_reg(8'd2, 16'hBEEF);
        set_reg(8'd1, 16'h0005);
        bus_wr(2'd0, 8'd2);
        read_word("R6");
        set_reg(8'd1, 16'hF805);
        bus_wr(2'd0, 8'd2);
        read_word("R6");

        // R3: low byte kept across a select change
        bus_wr(2'd2, 8'h21);
        bus_wr(2'd0, 8'd1);
        bus_wr(2'd3, 8'h00);
        bus_wr(2'd0, 8'd2);
        read_word("R3");

        // R2: the unused offset is ignored
        bus_wr(2'd1, 8'h01);
        bus_rd(2'd2, "R2");
        bus_rd(2'd2, "R2");

        // R9: unimplemented registers leave pointers and buffer alone
        set_reg(8'd7, 16'h1111);
        set_reg(8'd255, 16'h2222);
        bus_wr(2'd0, 8'd2);
        bus_rd(2'd2, "R9");
        bus_wr(2'd3, 8'h77);
        set_reg(8'd1, 16'h0041);
        bus_wr(2'd0, 8'd2);
        read_word("R9");

        // R10: reads with other selects
        bus_wr(2'd0, 8'd1);
        bus_rd(2'd3, "R10");
        bus_rd(2'd2, "R10");
        bus_wr(2'd0, 8'd2);
        bus_rd(2'd2, "R10");

        // constrained random traffic
        for (int it = 0; it < 600; it++) begin
            int op;
            op = int'($urandom_range(0, 5));
            case (op)
                0: begin
                    set_reg(8'd0, 16'($urandom()));
                    for (int k = 0; k < int'($urandom_range(1, 6)); k++)
                        set_reg(8'd2, 16'($urandom()));
                end
                1: begin
                    set_reg(8'd1, 16'($urandom()));
                    bus_wr(2'd0, 8'd2);
                    for (int k = 0; k < int'($urandom_range(1, 6)); k++) begin
                        bus_rd(2'd2, "R7");
                        bus_rd(2'd3, "R8");
                    end
                end
                2: set_reg(8'($urandom_range(3, 255)), 16'($urandom()));
                3: begin
                    bus_wr(2'd0, 8'($urandom_range(0, 5)));
                    bus_rd(2'($urandom_range(0, 3)), "R10");
                end
                4: bus_wr(2'($urandom_range(0, 3)), 8'($urandom_range(0, 3)));
                default: begin
                    bus_wr(2'd0, 8'd2);
                    bus_rd(2'($urandom_range(2, 3)), "R8");
                end
            endcase
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule